// File: doc/BRIEF.md
# Multi-Queue Stream Pacer

The pacer sits in the path of one to five independent packet streams. Each queue has a ready/valid stream input and a stream output. A beat passes straight through, with its data, byte-keep, sideband and end-of-packet marker unchanged. The only thing the pacer changes is when the beat may leave. It does this by holding the ready and valid handshake low for a number of idle cycles after every beat. Each queue can then run at full line rate or at a power-of-two fraction of it.

Software sets up every queue through a small register file reached over an AXI4-Lite slave. Each queue has three 32-bit words, laid out at a stride of 12 bytes:

- a hold word, which keeps the queue in soft reset for as long as it is nonzero;
- a pacing enable;
- a rate code.

With pacing disabled the queue acts as a wire. With pacing enabled and rate code N, the queue sends at one beat every 2^N cycles. Codes above 7 behave as 7. The queues share nothing except the register file.

Top module: `pkt_pacer`

## Requirements
- R1: After global reset, every register reads as zero, and every queue passes one beat per cycle while its output is ready.
- R2: Queue q owns three word-aligned 32-bit registers that read back exactly what was written: hold at byte address 12q, pacing enable at 12q+4, rate code at 12q+8.
- R3: A word address at or above 12 x NUM_Q reads as zero, and a write to it changes no register.
- R4: Each AXI4-Lite write and read takes a single beat and answers with response code 2'b00. A pending write response or read response stays valid, with its data stable, until the master accepts it.
- R5: While a queue's enable word is zero and its hold word is zero, its output valid equals its input valid and its input ready equals its output ready in the same cycle.
- R6: With pacing enabled and rate code N, consecutive beats of a queue that is always offered and always accepted are exactly 2^N cycles apart. A code above 7 gives a spacing of 128.
- R7: Beats leave in the order they arrived, none is lost, and data, keep, sideband and end-of-packet marker arrive unchanged.
- R8: While a queue's hold word is nonzero, its input ready and output valid are low. When the hold word returns to zero, the pending idle time is gone, and a waiting beat transfers in the first cycle after the write is accepted.
- R9: Pacing, holding or stalling one queue does not change the beat timing of another.
- R10: While a queue's output ready is low, its input ready is low and no beat transfers. Once the idle time has run out, its output valid follows its input valid. When output ready returns, the waiting beat transfers in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csr_awaddr | input | ADDR_W | Write address |
| csr_awvalid | input | 1 | Write address valid |
| csr_awready | output | 1 | Write address accepted |
| csr_wdata | input | 32 | Write data |
| csr_wvalid | input | 1 | Write data valid |
| csr_wready | output | 1 | Write data accepted |
| csr_bresp | output | 2 | Write response, always OKAY |
| csr_bvalid | output | 1 | Write response valid |
| csr_bready | input | 1 | Write response accepted |
| csr_araddr | input | ADDR_W | Read address |
| csr_arvalid | input | 1 | Read address valid |
| csr_arready | output | 1 | Read address accepted |
| csr_rdata | output | 32 | Read data |
| csr_rresp | output | 2 | Read response, always OKAY |
| csr_rvalid | output | 1 | Read data valid |
| csr_rready | input | 1 | Read data accepted |
| in_tdata | input | NUM_Q*DATA_W | Per-queue input data |
| in_tkeep | input | NUM_Q*KEEP_W | Per-queue input byte keep |
| in_tuser | input | NUM_Q*USER_W | Per-queue input sideband |
| in_tlast | input | NUM_Q | Per-queue input end of packet |
| in_tvalid | input | NUM_Q | Per-queue input valid |
| in_tready | output | NUM_Q | Per-queue input ready |
| out_tdata | output | NUM_Q*DATA_W | Per-queue output data |
| out_tkeep | output | NUM_Q*KEEP_W | Per-queue output byte keep |
| out_tuser | output | NUM_Q*USER_W | Per-queue output sideband |
| out_tlast | output | NUM_Q | Per-queue output end of packet |
| out_tvalid | output | NUM_Q | Per-queue output valid |
| out_tready | input | NUM_Q | Per-queue output ready |

## Verification
A register write takes effect on the stream side in the cycle right after the edge that accepts it. The write response is valid from that same cycle, and read data appears one cycle after the read address is accepted. The bench therefore checks configuration effects only after the write task has passed that acceptance edge. Stream behaviour is combinational within a cycle, so the bench changes stream controls only on the falling edge and samples handshakes 1 ns later. It records every transfer together with its falling-edge cycle number, and the beat spacing is compared with 2^N only after at least two beats have gone by at the new code. The check after a hold is released looks for a transfer at the very next sample, which any leftover idle count would delay.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int RATE_CODE_W   = 3;
  localparam int GAP_W         = (1 << RATE_CODE_W) - 1;
  localparam int MAX_RATE_CODE = GAP_W;
  localparam int REG_W         = 32;
  localparam int WORDS_PER_Q   = 3;
  localparam int Q_STRIDE      = WORDS_PER_Q * 4;
  localparam logic [1:0] RESP_OKAY = 2'b00;

  typedef enum logic [1:0] {
    FLD_HOLD = 2'd0,
    FLD_EN   = 2'd1,
    FLD_RATE = 2'd2
  } reg_field_e;

  typedef struct packed {
    logic                   hold;
    logic                   en;
    logic [RATE_CODE_W-1:0] code;
  } lane_cfg_t;
endpackage

// File: rtl/pp_csr.sv
module pp_csr #(
  parameter int NUM_Q  = 2,
  parameter int ADDR_W = 8
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic [ADDR_W-1:0]                       awaddr,
  input  logic                                    awvalid,
  output logic                                    awready,
  input  logic [pp_pkg::REG_W-1:0]                wdata,
  input  logic                                    wvalid,
  output logic                                    wready,
  output logic [1:0]                              bresp,
  output logic                                    bvalid,
  input  logic                                    bready,
  input  logic [ADDR_W-1:0]                       araddr,
  input  logic                                    arvalid,
  output logic                                    arready,
  output logic [pp_pkg::REG_W-1:0]                rdata,
  output logic [1:0]                              rresp,
  output logic                                    rvalid,
  input  logic                                    rready,
  output pp_pkg::lane_cfg_t [NUM_Q-1:0]           cfg_o
);
  import pp_pkg::*;

  logic [REG_W-1:0] hold_q [NUM_Q];
  logic [REG_W-1:0] hold_d [NUM_Q];
  logic [REG_W-1:0] en_q   [NUM_Q];
  logic [REG_W-1:0] en_d   [NUM_Q];
  logic [REG_W-1:0] rate_q [NUM_Q];
  logic [REG_W-1:0] rate_d [NUM_Q];

  logic             wr_go, rd_go;
  logic             bvalid_q, bvalid_d;
  logic             rvalid_q, rvalid_d;
  logic [REG_W-1:0] rdata_q, rdata_d;

  assign wr_go   = awvalid & wvalid & ~bvalid_q;
  assign rd_go   = arvalid & ~rvalid_q;
  assign awready = wr_go;
  assign wready  = wr_go;
  assign arready = ~rvalid_q;
  assign bvalid  = bvalid_q;
  assign bresp   = RESP_OKAY;
  assign rvalid  = rvalid_q;
  assign rresp   = RESP_OKAY;
  assign rdata   = rdata_q;

  // Write decode: only addresses that land on a configured queue word update state.
  always_comb begin
    hold_d = hold_q;
    en_d   = en_q;
    rate_d = rate_q;
    if (wr_go) begin
      for (int q = 0; q < NUM_Q; q++) begin
        for (int f = 0; f < WORDS_PER_Q; f++) begin
          if (awaddr == ADDR_W'(q * Q_STRIDE + f * 4)) begin
            case (reg_field_e'(f))
              FLD_HOLD: hold_d[q] = wdata;
              FLD_EN:   en_d[q]   = wdata;
              default:  rate_d[q] = wdata;
            endcase
          end
        end
      end
    end
  end

  // Read decode: unmatched addresses return zero.
  always_comb begin
    rdata_d = rdata_q;
    if (rd_go) begin
      rdata_d = '0;
      for (int q = 0; q < NUM_Q; q++) begin
        for (int f = 0; f < WORDS_PER_Q; f++) begin
          if (araddr == ADDR_W'(q * Q_STRIDE + f * 4)) begin
            case (reg_field_e'(f))
              FLD_HOLD: rdata_d = hold_q[q];
              FLD_EN:   rdata_d = en_q[q];
              default:  rdata_d = rate_q[q];
            endcase
          end
        end
      end
    end
  end

  always_comb begin
    bvalid_d = bvalid_q;
    if (wr_go)       bvalid_d = 1'b1;
    else if (bready) bvalid_d = 1'b0;
    rvalid_d = rvalid_q;
    if (rd_go)       rvalid_d = 1'b1;
    else if (rready) rvalid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int q = 0; q < NUM_Q; q++) begin
        hold_q[q] <= '0;
        en_q[q]   <= '0;
        rate_q[q] <= '0;
      end
    end else if (wr_go) begin
      hold_q <= hold_d;
      en_q   <= en_d;
      rate_q <= rate_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bvalid_q <= 1'b0;
      rvalid_q <= 1'b0;
    end else begin
      bvalid_q <= bvalid_d;
      rvalid_q <= rvalid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_go) rdata_q <= rdata_d;
  end

  for (genvar q = 0; q < NUM_Q; q++) begin : g_cfg
    assign cfg_o[q].hold = |hold_q[q];
    assign cfg_o[q].en   = |en_q[q];
    assign cfg_o[q].code = (rate_q[q] > REG_W'(MAX_RATE_CODE))
                         ? RATE_CODE_W'(MAX_RATE_CODE)
                         : rate_q[q][RATE_CODE_W-1:0];
  end
endmodule

// File: rtl/pp_gap_ctr.sv
module pp_gap_ctr (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           hold,
  input  logic                           en,
  input  logic [pp_pkg::RATE_CODE_W-1:0] code,
  input  logic                           fire,
  output logic                           open
);
  import pp_pkg::*;

  logic [GAP_W-1:0]       cnt_q, cnt_d;
  logic [GAP_W-1:0]       load_val;
  logic [RATE_CODE_W-1:0] shift_amt;
  logic                   cnt_en;

  // 2^code - 1 idle cycles, built as a right-shifted mask.
  assign shift_amt = RATE_CODE_W'(MAX_RATE_CODE) - code;
  assign load_val  = {GAP_W{1'b1}} >> shift_amt;

  assign cnt_en = hold | (fire & en) | (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (hold)              cnt_d = '0;
    else if (fire && en)   cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign open = ~en | (cnt_q == '0);
endmodule

// File: rtl/pp_lane.sv
module pp_lane #(
  parameter int DATA_W = 32,
  parameter int KEEP_W = 4,
  parameter int USER_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pp_pkg::lane_cfg_t cfg_i,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic [KEEP_W-1:0] s_tkeep,
  input  logic [USER_W-1:0] s_tuser,
  input  logic              s_tlast,
  input  logic              s_tvalid,
  output logic              s_tready,
  output logic [DATA_W-1:0] m_tdata,
  output logic [KEEP_W-1:0] m_tkeep,
  output logic [USER_W-1:0] m_tuser,
  output logic              m_tlast,
  output logic              m_tvalid,
  input  logic              m_tready
);
  logic open, gate, fire;

  assign gate = open & ~cfg_i.hold;
  assign fire = s_tvalid & m_tready & gate;

  pp_gap_ctr u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (cfg_i.hold),
    .en    (cfg_i.en),
    .code  (cfg_i.code),
    .fire  (fire),
    .open  (open)
  );

  assign s_tready = m_tready & gate;
  assign m_tvalid = s_tvalid & gate;
  assign m_tdata  = s_tdata;
  assign m_tkeep  = s_tkeep;
  assign m_tuser  = s_tuser;
  assign m_tlast  = s_tlast;
endmodule

// File: rtl/pkt_pacer.sv
module pkt_pacer #(
  parameter int NUM_Q  = 2,
  parameter int DATA_W = 32,
  parameter int KEEP_W = DATA_W / 8,
  parameter int USER_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          csr_awaddr,
  input  logic                       csr_awvalid,
  output logic                       csr_awready,
  input  logic [31:0]                csr_wdata,
  input  logic                       csr_wvalid,
  output logic                       csr_wready,
  output logic [1:0]                 csr_bresp,
  output logic                       csr_bvalid,
  input  logic                       csr_bready,
  input  logic [ADDR_W-1:0]          csr_araddr,
  input  logic                       csr_arvalid,
  output logic                       csr_arready,
  output logic [31:0]                csr_rdata,
  output logic [1:0]                 csr_rresp,
  output logic                       csr_rvalid,
  input  logic                       csr_rready,
  input  logic [NUM_Q*DATA_W-1:0]    in_tdata,
  input  logic [NUM_Q*KEEP_W-1:0]    in_tkeep,
  input  logic [NUM_Q*USER_W-1:0]    in_tuser,
  input  logic [NUM_Q-1:0]           in_tlast,
  input  logic [NUM_Q-1:0]           in_tvalid,
  output logic [NUM_Q-1:0]           in_tready,
  output logic [NUM_Q*DATA_W-1:0]    out_tdata,
  output logic [NUM_Q*KEEP_W-1:0]    out_tkeep,
  output logic [NUM_Q*USER_W-1:0]    out_tuser,
  output logic [NUM_Q-1:0]           out_tlast,
  output logic [NUM_Q-1:0]           out_tvalid,
  input  logic [NUM_Q-1:0]           out_tready
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  pp_pkg::lane_cfg_t [NUM_Q-1:0] cfg_w;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  pp_csr #(.NUM_Q(NUM_Q), .ADDR_W(ADDR_W)) u_csr (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .awaddr  (csr_awaddr),
    .awvalid (csr_awvalid),
    .awready (csr_awready),
    .wdata   (csr_wdata),
    .wvalid  (csr_wvalid),
    .wready  (csr_wready),
    .bresp   (csr_bresp),
    .bvalid  (csr_bvalid),
    .bready  (csr_bready),
    .araddr  (csr_araddr),
    .arvalid (csr_arvalid),
    .arready (csr_arready),
    .rdata   (csr_rdata),
    .rresp   (csr_rresp),
    .rvalid  (csr_rvalid),
    .rready  (csr_rready),
    .cfg_o   (cfg_w)
  );

  for (genvar q = 0; q < NUM_Q; q++) begin : g_lane
    pp_lane #(.DATA_W(DATA_W), .KEEP_W(KEEP_W), .USER_W(USER_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .cfg_i    (cfg_w[q]),
      .s_tdata  (in_tdata[q*DATA_W +: DATA_W]),
      .s_tkeep  (in_tkeep[q*KEEP_W +: KEEP_W]),
      .s_tuser  (in_tuser[q*USER_W +: USER_W]),
      .s_tlast  (in_tlast[q]),
      .s_tvalid (in_tvalid[q]),
      .s_tready (in_tready[q]),
      .m_tdata  (out_tdata[q*DATA_W +: DATA_W]),
      .m_tkeep  (out_tkeep[q*KEEP_W +: KEEP_W]),
      .m_tuser  (out_tuser[q*USER_W +: USER_W]),
      .m_tlast  (out_tlast[q]),
      .m_tvalid (out_tvalid[q]),
      .m_tready (out_tready[q])
    );
  end
endmodule

// File: rtl/pp_checks.sv
module pp_checks #(
  parameter int NUM_Q = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  pp_pkg::lane_cfg_t [NUM_Q-1:0] cfg,
  input  logic [NUM_Q-1:0]              s_tvalid,
  input  logic [NUM_Q-1:0]              s_tready,
  input  logic [NUM_Q-1:0]              m_tvalid,
  input  logic [NUM_Q-1:0]              m_tready,
  input  logic                          bvalid,
  input  logic                          bready,
  input  logic [1:0]                    bresp,
  input  logic                          rvalid,
  input  logic                          rready,
  input  logic [31:0]                   rdata
);
  a_r4_bresp_okay: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> (bresp == 2'b00));

  a_r4_bvalid_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> bvalid);

  a_r4_rdata_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> (rvalid && $stable(rdata)));

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    a_r8_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      cfg[q].hold |-> (!s_tready[q] && !m_tvalid[q]));

    a_r5_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg[q].en && !cfg[q].hold) |->
        ((m_tvalid[q] == s_tvalid[q]) && (s_tready[q] == m_tready[q])));

    a_r6_idle_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (s_tvalid[q] && s_tready[q] && cfg[q].en && !cfg[q].hold && (cfg[q].code != '0))
        |=> (!(s_tvalid[q] && s_tready[q]) || !cfg[q].en || cfg[q].hold));

    a_r10_no_ready_through: assert property (@(posedge clk) disable iff (!rst_n)
      !m_tready[q] |-> !s_tready[q]);
  end
endmodule

bind pkt_pacer pp_checks #(.NUM_Q(NUM_Q)) u_checks (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .cfg      (cfg_w),
  .s_tvalid (in_tvalid),
  .s_tready (in_tready),
  .m_tvalid (out_tvalid),
  .m_tready (out_tready),
  .bvalid   (csr_bvalid),
  .bready   (csr_bready),
  .bresp    (csr_bresp),
  .rvalid   (csr_rvalid),
  .rready   (csr_rready),
  .rdata    (csr_rdata)
);

// File: tb/pkt_pacer_bench.sv
`timescale 1ns/1ps
module pkt_pacer_bench;
  localparam int NQ = 2;
  localparam int DW = 32;
  localparam int KW = 4;
  localparam int UW = 8;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [AW-1:0] awaddr = '0, araddr = '0;
  logic awvalid = 1'b0, wvalid = 1'b0, bready = 1'b1, arvalid = 1'b0, rready = 1'b1;
  logic [31:0] wdata = '0;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata;

  logic [NQ*DW-1:0] in_tdata = '0;
  logic [NQ*KW-1:0] in_tkeep = '0;
  logic [NQ*UW-1:0] in_tuser = '0;
  logic [NQ-1:0] in_tlast = '0, in_tvalid = '0, out_tready = '0;
  logic [NQ-1:0] in_tready, out_tlast, out_tvalid;
  logic [NQ*DW-1:0] out_tdata;
  logic [NQ*KW-1:0] out_tkeep;
  logic [NQ*UW-1:0] out_tuser;

  pkt_pacer #(.NUM_Q(NQ), .DATA_W(DW), .KEEP_W(KW), .USER_W(UW), .ADDR_W(AW)) u_pkt_pacer (
    .clk(clk), .rst_n(rst_n),
    .csr_awaddr(awaddr), .csr_awvalid(awvalid), .csr_awready(awready),
    .csr_wdata(wdata), .csr_wvalid(wvalid), .csr_wready(wready),
    .csr_bresp(bresp), .csr_bvalid(bvalid), .csr_bready(bready),
    .csr_araddr(araddr), .csr_arvalid(arvalid), .csr_arready(arready),
    .csr_rdata(rdata), .csr_rresp(rresp), .csr_rvalid(rvalid), .csr_rready(rready),
    .in_tdata(in_tdata), .in_tkeep(in_tkeep), .in_tuser(in_tuser), .in_tlast(in_tlast),
    .in_tvalid(in_tvalid), .in_tready(in_tready),
    .out_tdata(out_tdata), .out_tkeep(out_tkeep), .out_tuser(out_tuser), .out_tlast(out_tlast),
    .out_tvalid(out_tvalid), .out_tready(out_tready)
  );

  int n_chk = 0, n_fail = 0, resp_err = 0;
  bit finished = 0;
  int cyc = 0;
  int fire_cnt [NQ];
  int last_fire [NQ];
  int last_gap [NQ];
  int beat_err [NQ];
  logic [DW-1:0] src_data [NQ];
  logic [DW-1:0] rx_exp [NQ];
  bit pend [NQ];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive_src(input int q);
    in_tdata[q*DW +: DW] = src_data[q];
    in_tuser[q*UW +: UW] = src_data[q][7:0] ^ 8'h5A;
    in_tkeep[q*KW +: KW] = src_data[q][3:0];
    in_tlast[q]          = src_data[q][0];
  endtask

  // Source and sink model: payload advances after each observed transfer.
  initial begin
    for (int q = 0; q < NQ; q++) begin
      src_data[q] = DW'(32'h100 + q * 32'h9000);
      rx_exp[q] = src_data[q];
      fire_cnt[q] = 0; last_fire[q] = 0; last_gap[q] = 0; beat_err[q] = 0; pend[q] = 0;
      drive_src(q);
    end
    forever begin
      @(negedge clk);
      cyc++;
      for (int q = 0; q < NQ; q++) begin
        if (pend[q]) begin
          src_data[q] = src_data[q] + 1;
          drive_src(q);
          pend[q] = 0;
        end
      end
      #1;
      for (int q = 0; q < NQ; q++) begin
        if (in_tvalid[q] && in_tready[q]) begin
          if (!(out_tvalid[q] && out_tdata[q*DW +: DW] == rx_exp[q]
                && out_tuser[q*UW +: UW] == (rx_exp[q][7:0] ^ 8'h5A)
                && out_tkeep[q*KW +: KW] == rx_exp[q][3:0]
                && out_tlast[q] == rx_exp[q][0]))
            beat_err[q]++;
          rx_exp[q] = rx_exp[q] + 1;
          fire_cnt[q]++;
          last_gap[q] = cyc - last_fire[q];
          last_fire[q] = cyc;
          pend[q] = 1;
        end
      end
    end
  end

  task automatic axi_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    awaddr = a; wdata = d; awvalid = 1'b1; wvalid = 1'b1;
    #2;
    while (!(awready && wready)) begin @(negedge clk); #2; end
    @(posedge clk); #1;
    awvalid = 1'b0; wvalid = 1'b0;
    if (!bvalid || bresp != 2'b00) resp_err++;
    @(posedge clk); #1;
  endtask

  task automatic axi_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    araddr = a; arvalid = 1'b1;
    #2;
    while (!arready) begin @(negedge clk); #2; end
    @(posedge clk); #1;
    arvalid = 1'b0;
    if (!rvalid || rresp != 2'b00) resp_err++;
    d = rdata;
    @(posedge clk); #1;
  endtask

  task automatic expect_reg(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    axi_read(a, v);
    chk(v == exp, req, $sformatf("read 0x%0h", a), v, exp);
  endtask

  task automatic t_reset;
    for (int i = 0; i < NQ * 3; i++) expect_reg(AW'(i * 4), 32'd0, "R1");
    @(negedge clk); in_tvalid = '1; out_tready = '1;
    repeat (10) @(negedge clk); #2;
    for (int q = 0; q < NQ; q++)
      chk(last_gap[q] == 1 && fire_cnt[q] >= 9, "R1", "full-rate spacing", last_gap[q], 1);
  endtask

  task automatic t_layout;
    axi_write(8'h08, 32'd3);
    axi_write(8'h10, 32'd1);
    axi_write(8'h14, 32'h25);
    axi_write(8'h0C, 32'hA5A5_0000);
    expect_reg(8'h00, 32'd0, "R2");
    expect_reg(8'h04, 32'd0, "R2");
    expect_reg(8'h08, 32'd3, "R2");
    expect_reg(8'h0C, 32'hA5A5_0000, "R2");
    expect_reg(8'h10, 32'd1, "R2");
    expect_reg(8'h14, 32'h25, "R2");
    for (int i = 0; i < NQ * 3; i++) axi_write(AW'(i * 4), 32'd0);
  endtask

  task automatic t_range;
    axi_write(8'h18, 32'hFFFF);
    axi_write(8'h1C, 32'd5);
    axi_write(8'hFC, 32'd7);
    expect_reg(8'h18, 32'd0, "R3");
    expect_reg(8'hFC, 32'd0, "R3");
    for (int i = 0; i < NQ * 3; i++) expect_reg(AW'(i * 4), 32'd0, "R3");
    repeat (10) @(negedge clk); #2;
    chk(last_gap[0] == 1 && last_gap[1] == 1, "R3", "traffic after stray writes", last_gap[0], 1);
  endtask

  task automatic t_resp;
    logic [31:0] v;
    chk(resp_err == 0, "R4", "OKAY responses so far", resp_err, 0);
    bready = 1'b0;
    axi_write(8'h08, 32'd2);
    repeat (3) @(negedge clk); #2;
    chk(bvalid == 1'b1 && bresp == 2'b00, "R4", "write response held", bvalid, 1);
    @(negedge clk); bready = 1'b1;
    @(posedge clk); #1;
    chk(bvalid == 1'b0, "R4", "write response released", bvalid, 0);
    rready = 1'b0;
    axi_read(8'h08, v);
    repeat (3) @(negedge clk); #2;
    chk(rvalid == 1'b1 && rdata == 32'd2, "R4", "read data held", rdata, 2);
    @(negedge clk); rready = 1'b1;
    @(posedge clk); #1;
    chk(rvalid == 1'b0, "R4", "read response released", rvalid, 0);
    axi_write(8'h08, 32'd0);
  endtask

  task automatic t_rate;
    axi_write(8'h08, 32'd1);
    axi_write(8'h04, 32'd1);
    repeat (20) @(negedge clk); #2;
    chk(last_gap[0] == 2, "R6", "code 1 spacing", last_gap[0], 2);
    chk(last_gap[1] == 1, "R9", "other queue at full rate", last_gap[1], 1);
    axi_write(8'h08, 32'd3);
    repeat (40) @(negedge clk); #2;
    chk(last_gap[0] == 8, "R6", "code 3 spacing", last_gap[0], 8);
    axi_write(8'h08, 32'd9);
    repeat (300) @(negedge clk); #2;
    chk(last_gap[0] == 128, "R6", "code 9 saturates", last_gap[0], 128);
    chk(last_gap[1] == 1, "R9", "other queue unchanged", last_gap[1], 1);
    axi_write(8'h04, 32'd0);
    repeat (10) @(negedge clk); #2;
    chk(last_gap[0] == 1, "R5", "disabled ignores rate code", last_gap[0], 1);
    chk(out_tvalid[0] == in_tvalid[0] && in_tready[0] == out_tready[0], "R5",
        "bypass handshake", out_tvalid[0], in_tvalid[0]);
  endtask

  task automatic t_hold;
    int fc, f1;
    axi_write(8'h08, 32'd7);
    axi_write(8'h04, 32'd1);
    fc = fire_cnt[0];
    while (fire_cnt[0] == fc) @(negedge clk);
    axi_write(8'h00, 32'd1);
    repeat (2) @(negedge clk); #2;
    chk(in_tready[0] == 1'b0 && out_tvalid[0] == 1'b0, "R8", "held queue blocked",
        {in_tready[0], out_tvalid[0]}, 0);
    f1 = fire_cnt[1];
    repeat (5) @(negedge clk); #2;
    chk(fire_cnt[1] - f1 == 5, "R9", "other queue runs during hold", fire_cnt[1] - f1, 5);
    fc = fire_cnt[0];
    axi_write(8'h00, 32'd0);
    chk(fire_cnt[0] == fc + 1, "R8", "beat right after release", fire_cnt[0] - fc, 1);
  endtask

  task automatic t_stall;
    int fc;
    axi_write(8'h08, 32'd2);
    @(negedge clk); out_tready[0] = 1'b0;
    repeat (140) @(negedge clk); #2;
    fc = fire_cnt[0];
    chk(in_tready[0] == 1'b0 && out_tvalid[0] == 1'b1, "R10", "stalled handshake",
        {in_tready[0], out_tvalid[0]}, 1);
    repeat (5) @(negedge clk); #2;
    chk(fire_cnt[0] == fc, "R10", "no transfer while stalled", fire_cnt[0] - fc, 0);
    chk(last_gap[1] == 1, "R9", "other queue ignores stall", last_gap[1], 1);
    @(negedge clk); out_tready[0] = 1'b1;
    @(negedge clk); #2;
    chk(fire_cnt[0] == fc + 1, "R10", "waiting beat goes at once", fire_cnt[0] - fc, 1);
    repeat (20) @(negedge clk); #2;
    chk(last_gap[0] == 4, "R6", "code 2 spacing after stall", last_gap[0], 4);
  endtask

  task automatic t_payload;
    for (int q = 0; q < NQ; q++)
      chk(beat_err[q] == 0 && fire_cnt[q] > 100, "R7", $sformatf("beats intact q%0d", q),
          beat_err[q], 0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_layout();
    t_range();
    t_resp();
    t_rate();
    t_hold();
    t_stall();
    t_payload();
    finish_run();
  end
endmodule